// File: doc/BRIEF.md
# Exception Entry Controller

This block takes the processor's exception requests and updates the architectural state that an exception entry changes. A normal request carries a cause code, the program counter of the faulting instruction and, for address-related faults, the faulting virtual address. The block chooses a dispatch vector (kernel, user, double or debug), saves the return PC into the correct save register, records the cause, and sets the exception-mode flag in the processor status word.

A separate debug request path is accepted only when the current interrupt level is below the configured debug level. When a debug exception is taken, the block saves the PC and the old status word into the save registers for the debug level and raises the interrupt level to that level. A taken exception of either kind produces a one-cycle redirect strobe and a registered vector index. A status write port lets the surrounding core load the status word, for example when it returns from a handler. Vector address lookup, pipeline flushing and request decode are done outside this block.

Top module: `exc_entry_ctrl`

## Requirements
- R1: After reset, the exception-mode bit, user bit, interrupt level, cause, debug cause, faulting address, every save register and the redirect strobe are all 0, and the vector index is kernel (code 0).
- R2: A normal request taken with exception mode clear and user bit clear produces vector kernel (code 0). The request's PC is written into the level-1 PC register.
- R3: A normal request taken with exception mode clear and user bit set produces vector user (code 1). The request's PC is written into the level-1 PC register.
- R4: A normal request taken with exception mode already set produces vector double (code 2). When HAS_DEPC=1, the PC goes to the double-exception PC register and the level-1 PC register keeps its value. When HAS_DEPC=0, the PC goes to the level-1 PC register and the double-exception PC output stays 0.
- R5: Every taken normal request writes its cause code into the cause register and sets the exception-mode bit. The user bit and interrupt level are left unchanged.
- R6: The faulting-address register is loaded from the request's address only when the request flags an address fault. Otherwise it keeps its value.
- R7: A debug request is taken only when the current interrupt level is strictly below DBG_LEVEL. An untaken debug request changes no state and raises no redirect.
- R8: A taken debug request produces vector debug (code 3) and writes the PC into the debug-level PC register. It also writes the old status word {user, exception mode, interrupt level} into the debug-level saved-status register, sets the interrupt level to DBG_LEVEL, sets exception mode, keeps the user bit and records the debug cause.
- R9: When a normal request and a debug request arrive in the same cycle, only the normal request is taken. The debug request is dropped and no debug-level register changes.
- R10: Each taken request raises the redirect strobe for exactly the cycle after the request. The vector index is updated on that same edge and held until the next taken request.
- R11: A status write loads the user bit, exception-mode bit and interrupt level when no request is taken in that cycle. It is ignored when a request is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| exc_req_i | input | 1 | Normal exception request |
| exc_cause_i | input | CAUSE_W | Cause code of the normal request |
| exc_pc_i | input | XLEN | Faulting PC, shared by both request paths |
| exc_has_vaddr_i | input | 1 | Request is address-related |
| exc_vaddr_i | input | XLEN | Faulting virtual address |
| dbg_req_i | input | 1 | Debug exception request |
| dbg_cause_i | input | DCAUSE_W | Debug cause bits |
| ps_wr_i | input | 1 | Status word write enable |
| ps_wr_um_i | input | 1 | User bit to write |
| ps_wr_excm_i | input | 1 | Exception-mode bit to write |
| ps_wr_il_i | input | IL_W | Interrupt level to write |
| redirect_o | output | 1 | One-cycle strobe for a taken exception |
| vector_o | output | 2 | Vector index: 0 kernel, 1 user, 2 double, 3 debug |
| ps_um_o | output | 1 | Status user bit |
| ps_excm_o | output | 1 | Status exception-mode bit |
| ps_intlevel_o | output | IL_W | Status interrupt level |
| cause_o | output | CAUSE_W | Cause register |
| vaddr_o | output | XLEN | Faulting address register |
| epc1_o | output | XLEN | Level-1 PC save register |
| depc_o | output | XLEN | Double-exception PC save register |
| epc_dbg_o | output | XLEN | Debug-level PC save register |
| eps_dbg_o | output | IL_W+2 | Debug-level saved status {um, excm, il} |
| dbg_cause_o | output | DCAUSE_W | Debug cause register |

## Verification
Wrong internal state shows up at the ports one edge after the request that exposes it. A stuck or misread exception-mode bit shows up as a wrong vector index and as the PC landing in the wrong save register. A bad interrupt-level compare shows up as a missing redirect, or a spurious one, on a debug request. The bench sweeps every combination of user bit, exception-mode bit and interrupt level against each request kind: normal, normal with an address, debug, and both together. It checks every output after each request, and checks one cycle later that the strobe has dropped. A second instance without the double-exception register covers the other save-register choice.

// File: rtl/exc_pkg.sv
package exc_pkg;
  localparam int unsigned IL_W = 4;

  typedef enum logic [1:0] {
    VEC_KERNEL = 2'd0,
    VEC_USER   = 2'd1,
    VEC_DOUBLE = 2'd2,
    VEC_DEBUG  = 2'd3
  } vec_e;

  typedef struct packed {
    logic            um;
    logic            excm;
    logic [IL_W-1:0] il;
  } ps_t;
endpackage

// File: rtl/exc_arbiter.sv
module exc_arbiter
  import exc_pkg::*;
#(
  parameter int unsigned DBG_LEVEL = 6
) (
  input  logic exc_req_i,
  input  logic dbg_req_i,
  input  ps_t  ps_i,
  output logic take_norm_o,
  output logic take_dbg_o,
  output vec_e vec_o
);
  localparam logic [IL_W-1:0] DbgIl = IL_W'(DBG_LEVEL);

  always_comb begin
    take_norm_o = exc_req_i;
    // debug loses to a normal request and is gated by level
    take_dbg_o  = dbg_req_i && !exc_req_i && (ps_i.il < DbgIl);
    if (take_dbg_o)     vec_o = VEC_DEBUG;
    else if (ps_i.excm) vec_o = VEC_DOUBLE;
    else if (ps_i.um)   vec_o = VEC_USER;
    else                vec_o = VEC_KERNEL;
  end
endmodule

// File: rtl/exc_status_reg.sv
module exc_status_reg
  import exc_pkg::*;
#(
  parameter int unsigned XLEN      = 32,
  parameter int unsigned CAUSE_W   = 6,
  parameter int unsigned DCAUSE_W  = 6,
  parameter int unsigned DBG_LEVEL = 6
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                take_norm_i,
  input  logic                take_dbg_i,
  input  logic [CAUSE_W-1:0]  cause_i,
  input  logic [DCAUSE_W-1:0] dcause_i,
  input  logic                has_vaddr_i,
  input  logic [XLEN-1:0]     vaddr_i,
  input  logic                ps_wr_i,
  input  ps_t                 ps_wr_val_i,
  output ps_t                 ps_o,
  output logic [CAUSE_W-1:0]  cause_o,
  output logic [DCAUSE_W-1:0] dcause_o,
  output logic [XLEN-1:0]     vaddr_o
);
  localparam logic [IL_W-1:0] DbgIl = IL_W'(DBG_LEVEL);

  ps_t ps_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ps_q     <= '0;
      cause_o  <= '0;
      dcause_o <= '0;
      vaddr_o  <= '0;
    end else begin
      if (take_norm_i) begin
        ps_q.excm <= 1'b1;
        cause_o   <= cause_i;
        if (has_vaddr_i) vaddr_o <= vaddr_i;
      end else if (take_dbg_i) begin
        ps_q.excm <= 1'b1;
        ps_q.il   <= DbgIl;
        dcause_o  <= dcause_i;
      end else if (ps_wr_i) begin
        ps_q <= ps_wr_val_i;
      end
    end
  end

  assign ps_o = ps_q;
endmodule

// File: rtl/exc_pc_save.sv
module exc_pc_save
  import exc_pkg::*;
#(
  parameter int unsigned XLEN     = 32,
  parameter bit          HAS_DEPC = 1'b1
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            take_norm_i,
  input  logic            take_dbg_i,
  input  logic            in_excm_i,
  input  logic [XLEN-1:0] pc_i,
  input  ps_t             ps_i,
  output logic [XLEN-1:0] epc1_o,
  output logic [XLEN-1:0] depc_o,
  output logic [XLEN-1:0] epc_dbg_o,
  output ps_t             eps_dbg_o
);
  logic to_depc;

  generate
    if (HAS_DEPC) begin : g_depc
      logic [XLEN-1:0] depc_q;
      assign to_depc = in_excm_i;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)                      depc_q <= '0;
        else if (take_norm_i && to_depc)  depc_q <= pc_i;
      end
      assign depc_o = depc_q;
    end else begin : g_no_depc
      assign to_depc = 1'b0;
      assign depc_o  = '0;
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      epc1_o    <= '0;
      epc_dbg_o <= '0;
      eps_dbg_o <= '0;
    end else begin
      if (take_norm_i && !to_depc) epc1_o <= pc_i;
      if (take_dbg_i) begin
        epc_dbg_o <= pc_i;
        eps_dbg_o <= ps_i;
      end
    end
  end
endmodule

// File: rtl/exc_entry_ctrl.sv
module exc_entry_ctrl
  import exc_pkg::*;
#(
  parameter int unsigned XLEN      = 32,
  parameter int unsigned CAUSE_W   = 6,
  parameter int unsigned DCAUSE_W  = 6,
  parameter int unsigned DBG_LEVEL = 6,
  parameter bit          HAS_DEPC  = 1'b1
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                exc_req_i,
  input  logic [CAUSE_W-1:0]  exc_cause_i,
  input  logic [XLEN-1:0]     exc_pc_i,
  input  logic                exc_has_vaddr_i,
  input  logic [XLEN-1:0]     exc_vaddr_i,
  input  logic                dbg_req_i,
  input  logic [DCAUSE_W-1:0] dbg_cause_i,
  input  logic                ps_wr_i,
  input  logic                ps_wr_um_i,
  input  logic                ps_wr_excm_i,
  input  logic [IL_W-1:0]     ps_wr_il_i,
  output logic                redirect_o,
  output logic [1:0]          vector_o,
  output logic                ps_um_o,
  output logic                ps_excm_o,
  output logic [IL_W-1:0]     ps_intlevel_o,
  output logic [CAUSE_W-1:0]  cause_o,
  output logic [XLEN-1:0]     vaddr_o,
  output logic [XLEN-1:0]     epc1_o,
  output logic [XLEN-1:0]     depc_o,
  output logic [XLEN-1:0]     epc_dbg_o,
  output logic [IL_W+1:0]     eps_dbg_o,
  output logic [DCAUSE_W-1:0] dbg_cause_o
);
  ps_t  ps;
  ps_t  ps_wr_val;
  ps_t  eps_dbg;
  logic take_norm, take_dbg;
  vec_e vec_sel, vec_q;

  assign ps_wr_val = '{um: ps_wr_um_i, excm: ps_wr_excm_i, il: ps_wr_il_i};

  exc_arbiter #(.DBG_LEVEL(DBG_LEVEL)) u_arb (
    .exc_req_i   (exc_req_i),
    .dbg_req_i   (dbg_req_i),
    .ps_i        (ps),
    .take_norm_o (take_norm),
    .take_dbg_o  (take_dbg),
    .vec_o       (vec_sel)
  );

  exc_status_reg #(
    .XLEN(XLEN), .CAUSE_W(CAUSE_W), .DCAUSE_W(DCAUSE_W), .DBG_LEVEL(DBG_LEVEL)
  ) u_status (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .take_norm_i (take_norm),
    .take_dbg_i  (take_dbg),
    .cause_i     (exc_cause_i),
    .dcause_i    (dbg_cause_i),
    .has_vaddr_i (exc_has_vaddr_i),
    .vaddr_i     (exc_vaddr_i),
    .ps_wr_i     (ps_wr_i),
    .ps_wr_val_i (ps_wr_val),
    .ps_o        (ps),
    .cause_o     (cause_o),
    .dcause_o    (dbg_cause_o),
    .vaddr_o     (vaddr_o)
  );

  exc_pc_save #(.XLEN(XLEN), .HAS_DEPC(HAS_DEPC)) u_save (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .take_norm_i (take_norm),
    .take_dbg_i  (take_dbg),
    .in_excm_i   (ps.excm),
    .pc_i        (exc_pc_i),
    .ps_i        (ps),
    .epc1_o      (epc1_o),
    .depc_o      (depc_o),
    .epc_dbg_o   (epc_dbg_o),
    .eps_dbg_o   (eps_dbg)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      redirect_o <= 1'b0;
      vec_q      <= VEC_KERNEL;
    end else begin
      redirect_o <= take_norm || take_dbg;
      if (take_norm || take_dbg) vec_q <= vec_sel;
    end
  end

  assign vector_o      = vec_q;
  assign ps_um_o       = ps.um;
  assign ps_excm_o     = ps.excm;
  assign ps_intlevel_o = ps.il;
  assign eps_dbg_o     = eps_dbg;
endmodule

// File: rtl/exc_entry_ctrl_chk.sv
module exc_entry_ctrl_chk
  import exc_pkg::*;
#(
  parameter int unsigned CAUSE_W   = 6,
  parameter int unsigned DBG_LEVEL = 6
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               exc_req_i,
  input logic [CAUSE_W-1:0] exc_cause_i,
  input logic               exc_has_vaddr_i,
  input logic               dbg_req_i,
  input logic               redirect_o,
  input logic [1:0]         vector_o,
  input logic               ps_excm_o,
  input logic [IL_W-1:0]    ps_intlevel_o,
  input logic [CAUSE_W-1:0] cause_o,
  input logic [31:0]        vaddr_lo
);
  localparam logic [IL_W-1:0] DbgIl = IL_W'(DBG_LEVEL);

  AST_NO_REQ_NO_REDIRECT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!exc_req_i && !dbg_req_i) |=> !redirect_o); // R10
  AST_REDIRECT_SETS_EXCM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exc_req_i |=> (redirect_o && ps_excm_o)); // R5
  AST_CAUSE_CAPTURED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exc_req_i |=> (cause_o == $past(exc_cause_i))); // R5
  AST_DOUBLE_VECTOR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (exc_req_i && ps_excm_o) |=> (vector_o == VEC_DOUBLE)); // R4
  AST_NORMAL_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exc_req_i |=> (vector_o != VEC_DEBUG)); // R9
  AST_DBG_GATED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dbg_req_i && !exc_req_i && ps_intlevel_o >= DbgIl) |=> !redirect_o); // R7
  AST_DBG_LEVEL_RAISED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dbg_req_i && !exc_req_i && ps_intlevel_o < DbgIl) |=>
      (ps_intlevel_o == DbgIl && ps_excm_o && vector_o == VEC_DEBUG)); // R8
  AST_VADDR_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (exc_req_i && !exc_has_vaddr_i) |=> $stable(vaddr_lo)); // R6
endmodule

bind exc_entry_ctrl exc_entry_ctrl_chk #(.CAUSE_W(CAUSE_W), .DBG_LEVEL(DBG_LEVEL)) u_chk (
  .clk_i           (clk_i),
  .rst_ni          (rst_ni),
  .exc_req_i       (exc_req_i),
  .exc_cause_i     (exc_cause_i),
  .exc_has_vaddr_i (exc_has_vaddr_i),
  .dbg_req_i       (dbg_req_i),
  .redirect_o      (redirect_o),
  .vector_o        (vector_o),
  .ps_excm_o       (ps_excm_o),
  .ps_intlevel_o   (ps_intlevel_o),
  .cause_o         (cause_o),
  .vaddr_lo        (vaddr_o[31:0])
);

// File: tb/exc_entry_ctrl_bench.sv
`timescale 1ns/1ps
module exc_entry_ctrl_bench;
  localparam int DBG = 6;

  logic clk = 1'b0, rst_n = 1'b0;
  logic exc_req = 0, has_va = 0, dbg_req = 0, ps_wr = 0, wr_um = 0, wr_excm = 0;
  logic [5:0] cause = 0, dcause = 0;
  logic [31:0] pc = 0, va = 0;
  logic [3:0] wr_il = 0;

  logic redir, redir_n, um, excm, um_n, excm_n;
  logic [1:0] vec, vec_n;
  logic [3:0] il, il_n;
  logic [5:0] cause_q, dcause_q, cause_n, dcause_n;
  logic [31:0] va_q, epc1, depc, epcd, va_n, epc1_n, depc_n, epcd_n;
  logic [5:0] eps, eps_n;

  int checks = 0, errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  exc_entry_ctrl #(.DBG_LEVEL(DBG), .HAS_DEPC(1'b1)) u_exc_entry_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .exc_req_i(exc_req), .exc_cause_i(cause),
    .exc_pc_i(pc), .exc_has_vaddr_i(has_va), .exc_vaddr_i(va),
    .dbg_req_i(dbg_req), .dbg_cause_i(dcause), .ps_wr_i(ps_wr),
    .ps_wr_um_i(wr_um), .ps_wr_excm_i(wr_excm), .ps_wr_il_i(wr_il),
    .redirect_o(redir), .vector_o(vec), .ps_um_o(um), .ps_excm_o(excm),
    .ps_intlevel_o(il), .cause_o(cause_q), .vaddr_o(va_q), .epc1_o(epc1),
    .depc_o(depc), .epc_dbg_o(epcd), .eps_dbg_o(eps), .dbg_cause_o(dcause_q));

  exc_entry_ctrl #(.DBG_LEVEL(DBG), .HAS_DEPC(1'b0)) u_exc_entry_ctrl_nodepc (
    .clk_i(clk), .rst_ni(rst_n), .exc_req_i(exc_req), .exc_cause_i(cause),
    .exc_pc_i(pc), .exc_has_vaddr_i(has_va), .exc_vaddr_i(va),
    .dbg_req_i(dbg_req), .dbg_cause_i(dcause), .ps_wr_i(ps_wr),
    .ps_wr_um_i(wr_um), .ps_wr_excm_i(wr_excm), .ps_wr_il_i(wr_il),
    .redirect_o(redir_n), .vector_o(vec_n), .ps_um_o(um_n), .ps_excm_o(excm_n),
    .ps_intlevel_o(il_n), .cause_o(cause_n), .vaddr_o(va_n), .epc1_o(epc1_n),
    .depc_o(depc_n), .epc_dbg_o(epcd_n), .eps_dbg_o(eps_n), .dbg_cause_o(dcause_n));

  // reference state
  logic m_um, m_excm; logic [3:0] m_il; logic [5:0] m_cause, m_dc, m_eps;
  logic [31:0] m_va, m_epc1, m_depc, m_epcd, m_epc1_nd; logic [1:0] m_vec;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic chk_all(input logic exp_redir);
    chk("R10 redirect", {31'b0, redir}, {31'b0, exp_redir});
    chk("R2 R3 R4 R8 vector", {30'b0, vec}, {30'b0, m_vec});
    chk("R5 R8 R11 ps", {26'b0, um, excm, il}, {26'b0, m_um, m_excm, m_il});
    chk("R5 cause", {26'b0, cause_q}, {26'b0, m_cause});
    chk("R6 vaddr", va_q, m_va);
    chk("R2 R3 epc1", epc1, m_epc1);
    chk("R4 depc", depc, m_depc);
    chk("R8 epc_dbg", epcd, m_epcd);
    chk("R8 eps_dbg", {26'b0, eps}, {26'b0, m_eps});
    chk("R8 dbg_cause", {26'b0, dcause_q}, {26'b0, m_dc});
    chk("R4 epc1 nodepc", epc1_n, m_epc1_nd);
    chk("R4 depc nodepc", depc_n, 32'h0);
    chk("R9 redirect nodepc", {31'b0, redir_n}, {31'b0, exp_redir});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    {m_um, m_excm, m_il, m_cause, m_dc, m_eps, m_va, m_epc1, m_depc, m_epcd, m_epc1_nd, m_vec} = '0;
    repeat (2) @(negedge clk);
    chk_all(1'b0); // R1
    rst_n = 1'b1;
    @(negedge clk);
    chk_all(1'b0); // R1 after release
    for (int st = 0; st < 64; st++) begin
      for (int kind = 0; kind < 5; kind++) begin
        logic tn, td, prev_excm;
        // load status; kind 4 also fires a request to show the write is ignored (R11)
        ps_wr = 1; wr_um = st[5]; wr_excm = st[4]; wr_il = st[3:0];
        @(negedge clk);
        ps_wr = 0;
        m_um = st[5]; m_excm = st[4]; m_il = st[3:0];
        chk_all(1'b0); // R11 write applied
        pc = 32'h4000_0000 + 32'(st * 64 + kind * 4);
        va = 32'hA000_0000 ^ pc;
        cause = 6'(st + kind);
        dcause = 6'(kind + 1);
        exc_req = (kind != 2);
        has_va  = (kind == 1);
        dbg_req = (kind == 2 || kind == 3);
        if (kind == 4) begin
          ps_wr = 1; wr_um = ~st[5]; wr_excm = ~st[4]; wr_il = ~st[3:0];
        end
        tn = exc_req;
        td = dbg_req && !exc_req && (m_il < 4'(DBG));
        prev_excm = m_excm;
        if (tn) begin
          m_vec = m_excm ? 2'd2 : (m_um ? 2'd1 : 2'd0);
          if (m_excm) m_depc = pc; else m_epc1 = pc;
          m_epc1_nd = pc;
          m_cause = cause; m_excm = 1;
          if (has_va) m_va = va;
        end else if (td) begin
          m_vec = 2'd3;
          m_epcd = pc; m_eps = {m_um, m_excm, m_il};
          m_il = 4'(DBG); m_excm = 1; m_dc = dcause;
        end
        @(negedge clk);
        exc_req = 0; dbg_req = 0; has_va = 0; ps_wr = 0;
        chk_all(tn || td); // R2..R9, R11 ignored on kind 4
        if (tn && prev_excm) chk("R4 double vec", {30'b0, vec}, 32'd2);
        @(negedge clk);
        chk("R10 strobe drops", {31'b0, redir}, 32'd0);
      end
    end
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule